// File: doc/BRIEF.md
# Key-Guarded Reset Watchdog

This block is a watchdog timer that sits in a power-management register space. Software reaches it over a 16-bit register write port, and reads come back through a combinational read port that shares the same address. Before any timeout or control setting can change, the correct 16-bit key has to be written to a lock register. A 32-bit timeout is written as two 16-bit halves. A control register holds a run bit and a separate reset-enable bit.

Two gates sit outside the lock: a module-enable bit and a clock-enable bit. The counter moves only while both are set. It steps down once for each single-cycle tick. The tick is a 32.768 kHz enable that has already been synchronised to the system clock. When the count runs out, the block does one of two things. If reset is enabled, it drives a system reset pulse of fixed width. If reset is not enabled, it sets a sticky expired flag and starts the timeout again.

Register map (12-bit byte offsets): load low 0x080, load high 0x084, control 0x088, status 0x08C, count low 0x090, count high 0x094, lock 0x0A0, module enable 0xC08, clock enable 0xC18. Unmapped offsets read as zero.

Top module: `keyed_reset_wdt`

## Requirements
- R1: Writing 0xE551 to offset 0x0A0 unlocks configuration. Any other value written there locks it again. Status bit 1 at offset 0x08C reads 1 while unlocked.
- R2: While locked, writes to 0x080, 0x084 and 0x088 are ignored, and their readback stays unchanged.
- R3: The timeout is {high half at 0x084, low half at 0x080}. Both halves read back at their own offsets. The live count reads back as its low half at 0x090 and its high half at 0x094.
- R4: A write to control bit 1 (run) while run was clear copies the 32-bit timeout into the count. A write to control while run is already set does not reload the count.
- R5: The count drops by one on each tick only when run is set, bit 2 at 0xC08 is set and bit 2 at 0xC18 is set. Otherwise the count holds.
- R6: With timeout L, expiry happens on the L-th counted tick, and L = 0 acts like 1. On expiry the count is reloaded. If control bit 3 is clear, the sticky flag goes to 1. The flag shows on expired_o and on status bit 0, and writing 1 to status bit 0 clears it.
- R7: On expiry with control bit 3 set, sys_rst_o is high for exactly 4 clock cycles, starting in the cycle after the expiry edge. An expiry during a pulse does not stretch the pulse, and the sticky flag is left unchanged.
- R8: After reset the block is locked, all registers and the count read 0, and sys_rst_o and expired_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Byte offset for both write and read |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Combinational read data for addr |
| tick | input | 1 | Single-cycle 32.768 kHz count enable |
| sys_rst_o | output | 1 | System reset pulse |
| expired_o | output | 1 | Sticky expiry flag |

## Verification
A register write takes effect at the clock edge where wr_en is sampled. Its result, including a run-start load of the count, can be read one edge later. A tick steps the count at the edge where it is sampled, and the expiry flag and the first cycle of the reset pulse appear at that same edge. The bench drives every input and samples every output on falling edges. It reads the combinational read port right after a write or tick has been consumed. For the reset pulse it counts falling edges and expects high at the first four and low at the fifth.

// File: rtl/krw_pkg.sv
package krw_pkg;
  localparam int unsigned REG_AW = 12;
  localparam int unsigned REG_DW = 16;
  localparam int unsigned CNT_W  = 2 * REG_DW;

  localparam logic [REG_AW-1:0] A_LOAD_LO = 12'h080;
  localparam logic [REG_AW-1:0] A_LOAD_HI = 12'h084;
  localparam logic [REG_AW-1:0] A_CTRL    = 12'h088;
  localparam logic [REG_AW-1:0] A_STAT    = 12'h08C;
  localparam logic [REG_AW-1:0] A_CNT_LO  = 12'h090;
  localparam logic [REG_AW-1:0] A_CNT_HI  = 12'h094;
  localparam logic [REG_AW-1:0] A_LOCK    = 12'h0A0;
  localparam logic [REG_AW-1:0] A_MOD_EN  = 12'hC08;
  localparam logic [REG_AW-1:0] A_CLK_EN  = 12'hC18;

  localparam logic [REG_DW-1:0] UNLOCK_KEY = 16'hE551;

  localparam int unsigned CTRL_RUN_BIT = 1;
  localparam int unsigned CTRL_RST_BIT = 3;
  localparam int unsigned GATE_BIT     = 2;
  localparam int unsigned STAT_EXP_BIT = 0;
  localparam int unsigned STAT_UNL_BIT = 1;

  // The count is at its last step when one (or zero) remains.
  function automatic logic at_terminal(input logic [CNT_W-1:0] c);
    return c <= CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c,
                                                  input logic [CNT_W-1:0] load);
    return at_terminal(c) ? load : c - CNT_W'(1);
  endfunction
endpackage

// File: rtl/krw_regfile.sv
module krw_regfile
  import krw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_DW-1:0] wr_data,
  input  logic              expire_evt,
  input  logic [CNT_W-1:0]  count,
  output logic [REG_DW-1:0] rd_data,
  output logic [CNT_W-1:0]  load_val,
  output logic              run,
  output logic              rst_en,
  output logic              gates_on,
  output logic              run_start,
  output logic              unlocked,
  output logic              expired
);
  logic [REG_DW-1:0] lo_q, hi_q, mod_q, clk_q;
  logic run_q, rst_en_q, unl_q, exp_q;

  logic wr_cfg_lo, wr_cfg_hi, wr_ctrl, wr_stat, wr_lock;
  assign wr_cfg_lo = wr_en && unl_q && (addr == A_LOAD_LO);
  assign wr_cfg_hi = wr_en && unl_q && (addr == A_LOAD_HI);
  assign wr_ctrl   = wr_en && unl_q && (addr == A_CTRL);
  assign wr_stat   = wr_en && (addr == A_STAT);
  assign wr_lock   = wr_en && (addr == A_LOCK);

  assign run_start = wr_ctrl && wr_data[CTRL_RUN_BIT] && !run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q     <= '0;
      hi_q     <= '0;
      mod_q    <= '0;
      clk_q    <= '0;
      run_q    <= 1'b0;
      rst_en_q <= 1'b0;
      unl_q    <= 1'b0;
      exp_q    <= 1'b0;
    end else begin
      if (wr_cfg_lo) lo_q <= wr_data;
      if (wr_cfg_hi) hi_q <= wr_data;
      if (wr_ctrl) begin
        run_q    <= wr_data[CTRL_RUN_BIT];
        rst_en_q <= wr_data[CTRL_RST_BIT];
      end
      if (wr_en && addr == A_MOD_EN) mod_q <= wr_data;
      if (wr_en && addr == A_CLK_EN) clk_q <= wr_data;
      if (wr_lock) unl_q <= (wr_data == UNLOCK_KEY);
      if (expire_evt && !rst_en_q)
        exp_q <= 1'b1;
      else if (wr_stat && wr_data[STAT_EXP_BIT])
        exp_q <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    case (addr)
      A_LOAD_LO: rd_data = lo_q;
      A_LOAD_HI: rd_data = hi_q;
      A_CTRL: begin
        rd_data[CTRL_RUN_BIT] = run_q;
        rd_data[CTRL_RST_BIT] = rst_en_q;
      end
      A_STAT: begin
        rd_data[STAT_EXP_BIT] = exp_q;
        rd_data[STAT_UNL_BIT] = unl_q;
      end
      A_CNT_LO: rd_data = count[REG_DW-1:0];
      A_CNT_HI: rd_data = count[CNT_W-1:REG_DW];
      A_LOCK:   rd_data[0] = unl_q;
      A_MOD_EN: rd_data = mod_q;
      A_CLK_EN: rd_data = clk_q;
      default:  rd_data = '0;
    endcase
  end

  assign load_val = {hi_q, lo_q};
  assign run      = run_q;
  assign rst_en   = rst_en_q;
  assign gates_on = mod_q[GATE_BIT] && clk_q[GATE_BIT];
  assign unlocked = unl_q;
  assign expired  = exp_q;
endmodule

// File: rtl/krw_counter.sv
module krw_counter
  import krw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_start,
  input  logic             step_en,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             expire_evt
);
  logic [CNT_W-1:0] cnt_q;

  assign expire_evt = step_en && !run_start && at_terminal(cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (run_start)
      cnt_q <= load_val;
    else if (step_en)
      cnt_q <= next_count(cnt_q, load_val);
  end

  assign count = cnt_q;
endmodule

// File: rtl/krw_pulse.sv
module krw_pulse #(
  parameter int unsigned PULSE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trigger,
  output logic pulse
);
  localparam int unsigned PW = $clog2(PULSE_CYCLES + 1);
  logic [PW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      left_q <= '0;
    else if (left_q == '0) begin
      if (trigger) left_q <= PW'(PULSE_CYCLES);
    end else
      left_q <= left_q - PW'(1);
  end

  assign pulse = (left_q != '0);
endmodule

// File: rtl/keyed_reset_wdt.sv
module keyed_reset_wdt
  import krw_pkg::*;
#(
  parameter int unsigned PULSE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_DW-1:0] wr_data,
  output logic [REG_DW-1:0] rd_data,
  input  logic              tick,
  output logic              sys_rst_o,
  output logic              expired_o
);
  logic [CNT_W-1:0] load_val, count;
  logic run, rst_en, gates_on, run_start, unlocked, expire_evt, step_en;

  krw_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .expire_evt(expire_evt), .count(count), .rd_data(rd_data),
    .load_val(load_val), .run(run), .rst_en(rst_en), .gates_on(gates_on),
    .run_start(run_start), .unlocked(unlocked), .expired(expired_o)
  );

  assign step_en = tick && run && gates_on;

  krw_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .run_start(run_start), .step_en(step_en),
    .load_val(load_val), .count(count), .expire_evt(expire_evt)
  );

  krw_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
    .clk(clk), .rst_n(rst_n), .trigger(expire_evt && rst_en), .pulse(sys_rst_o)
  );
endmodule

// File: rtl/krw_chk.sv
module krw_chk
  import krw_pkg::*;
#(
  parameter int unsigned PULSE_CYCLES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [REG_AW-1:0] addr,
  input logic [REG_DW-1:0] wr_data,
  input logic              unlocked,
  input logic [CNT_W-1:0]  load_val,
  input logic [CNT_W-1:0]  count,
  input logic              gates_on,
  input logic              run_start,
  input logic              expire_evt,
  input logic              rst_en,
  input logic              sys_rst_o,
  input logic              expired_o
);
  logic [7:0] hi_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_len <= '0;
    else if (sys_rst_o) hi_len <= (hi_len == 8'hFF) ? hi_len : hi_len + 8'd1;
    else hi_len <= '0;
  end

  assert_unlock_key_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_LOCK) |=> (unlocked == ($past(wr_data) == UNLOCK_KEY)));

  assert_locked_ignore_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !unlocked && (addr == A_LOAD_LO || addr == A_LOAD_HI)) |=> $stable(load_val));

  assert_gate_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!gates_on && !run_start) |=> $stable(count));

  assert_soft_expire_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_evt && !rst_en) |=> expired_o);

  assert_pulse_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_evt && rst_en && !sys_rst_o) |=> sys_rst_o);

  assert_pulse_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst_o) |-> (hi_len == 8'(PULSE_CYCLES)));

  assert_pulse_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_o |-> (hi_len < 8'(PULSE_CYCLES)));
endmodule

bind keyed_reset_wdt krw_chk #(.PULSE_CYCLES(PULSE_CYCLES)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .unlocked(unlocked), .load_val(load_val), .count(count), .gates_on(gates_on),
  .run_start(run_start), .expire_evt(expire_evt), .rst_en(rst_en),
  .sys_rst_o(sys_rst_o), .expired_o(expired_o)
);

// File: tb/keyed_reset_wdt_tb_top.sv
module keyed_reset_wdt_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        tick = 1'b0;
  logic        sys_rst_o, expired_o;

  int vectors = 0;
  int fails = 0;

  localparam logic [11:0] LO = 12'h080, HI = 12'h084, CTL = 12'h088, ST = 12'h08C,
                          CLO = 12'h090, CHI = 12'h094, LK = 12'h0A0,
                          MEN = 12'hC08, CEN = 12'hC18;
  localparam logic [15:0] KEY = 16'hE551;
  localparam logic [15:0] RUN = 16'h0002, RUN_RST = 16'h000A;

  always #5 clk = ~clk;

  keyed_reset_wdt dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .tick(tick), .sys_rst_o(sys_rst_o), .expired_o(expired_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [15:0] v);
    addr = a;
    #1 v = rd_data;
  endtask

  task automatic tick_once();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic t_reset_R8();
    logic [15:0] v;
    rd(ST, v);  chk("R8", "status", v, 0);
    rd(CTL, v); chk("R8", "control", v, 0);
    rd(LO, v);  chk("R8", "load lo", v, 0);
    rd(CLO, v); chk("R8", "count lo", v, 0);
    chk("R8", "sys_rst_o", sys_rst_o, 0);
    chk("R8", "expired_o", expired_o, 0);
  endtask

  task automatic t_locked_R2();
    logic [15:0] v;
    wr(LO, 16'h1234); wr(HI, 16'h5678); wr(CTL, RUN_RST);
    rd(LO, v);  chk("R2", "load lo locked", v, 0);
    rd(HI, v);  chk("R2", "load hi locked", v, 0);
    rd(CTL, v); chk("R2", "control locked", v, 0);
    rd(CLO, v); chk("R2", "count untouched", v, 0);
  endtask

  task automatic t_key_R1();
    logic [15:0] v;
    wr(LK, KEY);      rd(ST, v); chk("R1", "unlocked after key", v, 16'h0002);
    wr(LK, 16'h0001); rd(ST, v); chk("R1", "relocked by wrong key", v, 0);
    wr(LO, 16'h0077); rd(LO, v); chk("R1", "write after relock ignored", v, 0);
    wr(LK, KEY);      rd(ST, v); chk("R1", "unlocked again", v, 16'h0002);
  endtask

  task automatic t_split_R3_R4();
    logic [15:0] v;
    wr(LO, 16'h0005); wr(HI, 16'h0001);
    rd(LO, v); chk("R3", "load lo readback", v, 16'h0005);
    rd(HI, v); chk("R3", "load hi readback", v, 16'h0001);
    wr(CTL, RUN);
    rd(CLO, v); chk("R4", "count lo after run", v, 16'h0005);
    rd(CHI, v); chk("R3", "count hi after run", v, 16'h0001);
    wr(LO, 16'h0009); wr(CTL, RUN);
    rd(CLO, v); chk("R4", "no reload while running", v, 16'h0005);
    wr(CTL, 16'h0000);
  endtask

  task automatic t_gate_R5();
    logic [15:0] v;
    wr(HI, 16'h0000); wr(LO, 16'h0004); wr(CTL, RUN);
    rd(CLO, v); chk("R5", "loaded", v, 16'h0004);
    tick_once(); rd(CLO, v); chk("R5", "no gates, held", v, 16'h0004);
    wr(MEN, 16'h0004);
    tick_once(); rd(CLO, v); chk("R5", "module only, held", v, 16'h0004);
    wr(CEN, 16'h0004);
    tick_once(); rd(CLO, v); chk("R5", "both gates, stepped", v, 16'h0003);
    wr(MEN, 16'h0000);
    tick_once(); rd(CLO, v); chk("R5", "module cleared, held", v, 16'h0003);
    wr(MEN, 16'h0004); wr(CTL, 16'h0000);
    tick_once(); rd(CLO, v); chk("R5", "run cleared, held", v, 16'h0003);
  endtask

  task automatic t_soft_R6();
    logic [15:0] v;
    wr(LO, 16'h0003); wr(CTL, RUN);
    tick_once(); tick_once();
    chk("R6", "not yet expired", expired_o, 0);
    rd(CLO, v); chk("R6", "count before expiry", v, 16'h0001);
    tick_once();
    chk("R6", "expired on 3rd tick", expired_o, 1);
    chk("R6", "no reset pulse", sys_rst_o, 0);
    rd(ST, v);  chk("R6", "status flag", v, 16'h0003);
    rd(CLO, v); chk("R6", "reloaded", v, 16'h0003);
    wr(ST, 16'h0001);
    chk("R6", "flag cleared", expired_o, 0);
    wr(CTL, 16'h0000); wr(LO, 16'h0000); wr(CTL, RUN);
    tick_once();
    chk("R6", "zero load expires on 1st tick", expired_o, 1);
    wr(ST, 16'h0001); wr(CTL, 16'h0000);
  endtask

  task automatic t_hard_R7();
    logic [15:0] v;
    wr(LO, 16'h0002); wr(CTL, RUN_RST);
    tick_once();
    chk("R7", "no pulse before expiry", sys_rst_o, 0);
    tick_once();
    for (int i = 0; i < 4; i++) begin
      chk("R7", $sformatf("pulse high cycle %0d", i + 1), sys_rst_o, 1);
      if (i < 3) @(negedge clk);
    end
    @(negedge clk);
    chk("R7", "pulse low after 4 cycles", sys_rst_o, 0);
    chk("R7", "sticky flag untouched", expired_o, 0);
    rd(CLO, v); chk("R7", "reloaded", v, 16'h0002);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_R8();
    t_locked_R2();
    t_key_R1();
    t_split_R3_R4();
    t_gate_R5();
    t_soft_R6();
    t_hard_R7();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule